// File: doc/BRIEF.md
# Fitness-Scaled Clone Mutation Engine

This block is the hardware core of a clone-based evolutionary loop over fixed-length bit-string individuals. It holds a pool of slots. The low slots hold the parent population, and the remaining slots hold several cloned copies of those parents. An external evaluator scores the individuals and writes the scores back through a fitness port. The engine then does the work that falls between evaluations.

Three commands drive it: seed, mutate and select.

- **Seed** fills the parents from an internal pseudo-random generator.
- **Mutate** rebuilds every clone from its parent and flips a number of distinct, randomly placed bits. That number falls as the parent's fitness approaches the best fitness among the parents. A baseline mode instead flips a fixed count in every clone. Parents themselves are never changed.
- **Select** ranks parents and clones together by fitness and keeps the best as the next parents.

Any slot can be read back at any time through a combinational readout port.

Top module: `clone_mut_engine`

## Requirements
- R1: After reset every slot holds genome 0 and fitness 0, `busy` is 0 and `done` is 0.
- R2: Command code 0 (seed) loads parent slots 0..NPAR-1 with successive states of a free-running 16-bit maximal-length LFSR. With LEN=16 the seeded genomes are therefore nonzero and pairwise distinct. It also sets their fitness to 0.
- R3: Command code 1 (mutate) with `base_mode`=0 writes every clone slot s in NPAR..TOTAL-1 as a copy of parent slot s mod NPAR. In that copy exactly n distinct bit positions are inverted, so the Hamming distance to the parent is n. Here n = floor(k·(M−f)/M), k is `k_scale` sampled at start, M is the largest parent fitness and f is the parent's own fitness.
- R4: The flip count is clamped to LEN. When M is 0 the count is k, clamped to LEN.
- R5: Mutate with `base_mode`=1 flips exactly 8 distinct bits in every clone, whatever the fitness values.
- R6: A mutate command leaves the genome and fitness of every parent slot unchanged.
- R7: Command code 2 (select) ranks all TOTAL slots by fitness, highest first. Among equal fitness the lower slot index ranks first, so parents precede clones. The first NPAR entries of that ranking, genome and fitness together, are written to slots 0..NPAR-1 in rank order, with slot 0 holding the best.
- R8: A fitness write (`fit_we`) is applied only while the engine is idle. A write issued while `busy` is high has no effect.
- R9: A start pulse while idle raises `busy` from the next cycle until the command finishes. `done` is high for exactly one cycle, in the same cycle that `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken only when idle |
| op | input | 2 | Command: 0 seed, 1 mutate, 2 select, 3 none |
| base_mode | input | 1 | Mutate with a constant count of 8 flips |
| k_scale | input | KW | Scale factor k for the fitness-scaled flip count |
| fit_we | input | 1 | Fitness write enable |
| fit_addr | input | IW | Slot to which the fitness is written |
| fit_data | input | FW | Fitness value |
| rd_addr | input | IW | Slot to read |
| rd_genome | output | LEN | Genome of the addressed slot |
| rd_fit | output | FW | Fitness of the addressed slot |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Zero best parent fitness.** A divider that did not guard this case would hang or yield zero flips, where the requirement is k flips.
- **k larger than the string length.** Without clamping, the engine would loop forever looking for a free bit position.
- **Repeated flip positions.** A design that let a position repeat would show a Hamming distance below the required count, because the second flip cancels the first.
- **Ties across the parent–clone boundary.** These expose an unstable sort that lets a clone displace an equally fit parent.
- **Fitness writes while busy.** These expose a port that corrupts a parent's score while a command is running.

// File: rtl/clone_mut_engine.sv
module clone_mut_engine #(
  parameter int NPAR       = 16,
  parameter int NCLONE     = 3,
  parameter int LEN        = 16,
  parameter int FW         = 8,
  parameter int KW         = 5,
  parameter int BASE_FLIPS = 8,
  localparam int TOTAL     = NPAR * (NCLONE + 1),
  localparam int IW        = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          base_mode,
  input  logic [KW-1:0] k_scale,
  input  logic          fit_we,
  input  logic [IW-1:0] fit_addr,
  input  logic [FW-1:0] fit_data,
  input  logic [IW-1:0] rd_addr,
  output logic [LEN-1:0] rd_genome,
  output logic [FW-1:0] rd_fit,
  output logic          busy,
  output logic          done
);
  localparam int PIW = $clog2(NPAR);
  localparam int PW  = $clog2(LEN);
  localparam int CW  = $clog2(LEN + 1);
  localparam int NW  = FW + KW;
  localparam int NCL = NPAR * NCLONE;

  typedef enum logic [2:0] {S_IDLE, S_SEED, S_PREP, S_DIV, S_FLIP, S_SEL, S_COMMIT} st_t;
  st_t st;

  logic [LEN-1:0] pop [TOTAL];
  logic [FW-1:0]  fit [TOTAL];
  logic [IW-1:0]  sel [NPAR];
  logic [15:0]    lfsr;
  logic [IW-1:0]  ctr, bidx, par, nidx;
  logic [PIW-1:0] rnd;
  logic [NW-1:0]  num;
  logic [KW-1:0]  quot, k_r;
  logic [CW-1:0]  left;
  logic [LEN-1:0] mask, seed_g;
  logic [TOTAL-1:0] taken;
  logic [FW-1:0]  bfit, maxf;
  logic           base_r, have, cand, pos_ok, mutating;
  logic [PW-1:0]  pos;

  function automatic logic [CW-1:0] clampc(input logic [NW-1:0] v);
    return (v > NW'(LEN)) ? CW'(LEN) : CW'(v);
  endfunction

  always_comb begin
    maxf = '0;
    for (int i = 0; i < NPAR; i++) if (fit[i] > maxf) maxf = fit[i];
    for (int b = 0; b < LEN; b++) seed_g[b] = lfsr[b % 16];
  end

  assign busy      = (st != S_IDLE);
  assign mutating  = (st == S_PREP) || (st == S_DIV) || (st == S_FLIP);
  assign rd_genome = pop[rd_addr];
  assign rd_fit    = fit[rd_addr];
  assign par       = IW'(ctr % NPAR);
  assign pos       = lfsr[PW-1:0];
  assign pos_ok    = (int'(pos) < LEN) && !mask[pos];
  assign cand      = !taken[ctr] && (!have || fit[ctr] > bfit);
  assign nidx      = cand ? ctr : bidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; lfsr <= 16'hACE1;
      ctr <= '0; bidx <= '0; rnd <= '0; num <= '0; quot <= '0; k_r <= '0;
      left <= '0; mask <= '0; taken <= '0; bfit <= '0; base_r <= 1'b0; have <= 1'b0;
      for (int i = 0; i < TOTAL; i++) begin pop[i] <= '0; fit[i] <= '0; end
      for (int i = 0; i < NPAR; i++) sel[i] <= '0;
    end else begin
      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (fit_we) fit[fit_addr] <= fit_data;
          if (start) begin
            ctr <= '0;
            case (op)
              2'd0: st <= S_SEED;
              2'd1: begin k_r <= k_scale; base_r <= base_mode; st <= S_PREP; end
              2'd2: begin rnd <= '0; taken <= '0; have <= 1'b0; st <= S_SEL; end
              default: st <= S_IDLE;
            endcase
          end
        end
        S_SEED: begin
          pop[ctr] <= seed_g;
          fit[ctr] <= '0;
          if (ctr == IW'(NPAR - 1)) begin st <= S_IDLE; done <= 1'b1; end
          else ctr <= ctr + 1'b1;
        end
        S_PREP: begin
          mask <= '0;
          if (base_r) begin left <= clampc(NW'(BASE_FLIPS)); st <= S_FLIP; end
          else begin
            num  <= NW'(k_r) * NW'(maxf - fit[par]);
            quot <= '0;
            st   <= S_DIV;
          end
        end
        S_DIV: begin
          if (maxf != '0 && num >= NW'(maxf)) begin
            num  <= num - NW'(maxf);
            quot <= quot + 1'b1;
          end else begin
            left <= (maxf == '0) ? clampc(NW'(k_r)) : clampc(NW'(quot));
            st   <= S_FLIP;
          end
        end
        S_FLIP: begin
          if (left == '0) begin
            pop[IW'(NPAR) + ctr] <= pop[par] ^ mask;
            if (ctr == IW'(NCL - 1)) begin st <= S_IDLE; done <= 1'b1; end
            else begin ctr <= ctr + 1'b1; st <= S_PREP; end
          end else if (pos_ok) begin
            mask[pos] <= 1'b1;
            left      <= left - CW'(1);
          end
        end
        S_SEL: begin
          if (cand) begin bidx <= ctr; bfit <= fit[ctr]; have <= 1'b1; end
          if (ctr == IW'(TOTAL - 1)) begin
            sel[rnd]    <= nidx;
            taken[nidx] <= 1'b1;
            have        <= 1'b0;
            ctr         <= '0;
            if (rnd == PIW'(NPAR - 1)) st <= S_COMMIT;
            else rnd <= rnd + 1'b1;
          end else ctr <= ctr + 1'b1;
        end
        S_COMMIT: begin
          for (int i = 0; i < NPAR; i++) begin
            pop[i] <= pop[sel[i]];
            fit[i] <= fit[sel[i]];
          end
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clone_mut_engine_chk.sv
module clone_mut_engine_chk #(
  parameter int LEN = 16,
  parameter int FW  = 8,
  localparam int CW = $clog2(LEN + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           mutating,
  input logic [LEN-1:0] par0,
  input logic [FW-1:0]  fit0,
  input logic [CW-1:0]  left
);
  a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r6_parent_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mutating && $past(mutating)) |-> $stable(par0));
  a_r8_fit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mutating && $past(mutating)) |-> $stable(fit0));
  a_r4_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    int'(left) <= LEN);
endmodule

bind clone_mut_engine clone_mut_engine_chk #(.LEN(LEN), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mutating(mutating),
  .par0(pop[0]), .fit0(fit[0]), .left(left)
);

// File: tb/clone_mut_engine_tb_top.sv
module clone_mut_engine_tb_top;
  localparam int NPAR = 16, TOTAL = 64, LEN = 16, FW = 8, KW = 5, IW = 6;
  localparam int K_GEN = 0, K_FIT = 1, K_HAM = 2;

  logic clk = 0, rst_n = 0, start = 0, base_mode = 0, fit_we = 0;
  logic [1:0] op = 0;
  logic [KW-1:0] k_scale = 0;
  logic [IW-1:0] fit_addr = 0, rd_addr = 0;
  logic [FW-1:0] fit_data = 0;
  logic [LEN-1:0] rd_genome;
  logic [FW-1:0] rd_fit;
  logic busy, done;

  always #10 clk = ~clk;

  clone_mut_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_mode(base_mode),
    .k_scale(k_scale), .fit_we(fit_we), .fit_addr(fit_addr), .fit_data(fit_data),
    .rd_addr(rd_addr), .rd_genome(rd_genome), .rd_fit(rd_fit), .busy(busy), .done(done)
  );

  typedef struct { int kind; int exp; logic [LEN-1:0] refg; int req; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  logic [LEN-1:0] g_pool [TOTAL];
  int f_pool [TOTAL];

  always @(negedge clk) begin
    if (q.size() != 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        K_GEN:   act = int'(rd_genome);
        K_FIT:   act = int'(rd_fit);
        default: act = $countones(rd_genome ^ it.refg);
      endcase
      checks++;
      if (act != it.exp) begin
        fails++;
        $display("FAIL R%0d slot=%0d kind=%0d actual=%0d expected=%0d", it.req, rd_addr, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_slot(input int idx, input int kind, input int exp, input logic [LEN-1:0] refg, input int req);
    item_t it;
    @(posedge clk); #2;
    rd_addr = IW'(idx);
    it.kind = kind; it.exp = exp; it.refg = refg; it.req = req;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk(input int act, input int exp, input int req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic peek_all();
    for (int i = 0; i < TOTAL; i++) begin
      rd_addr = IW'(i); #1;
      g_pool[i] = rd_genome; f_pool[i] = int'(rd_fit);
    end
  endtask

  task automatic wfit(input int idx, input int val);
    @(posedge clk); #2;
    fit_we = 1; fit_addr = IW'(idx); fit_data = FW'(val);
    @(posedge clk); #2;
    fit_we = 0;
  endtask

  task automatic cmd(input int code, input bit base, input int k);
    @(posedge clk); #2;
    start = 1; op = 2'(code); base_mode = base; k_scale = KW'(k);
    @(posedge clk); #2;
    start = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  function automatic int exp_flips(input int k, input int m, input int f);
    int n;
    n = (m == 0) ? k : (k * (m - f)) / m;
    return (n > LEN) ? LEN : n;
  endfunction

  task automatic check_mutation(input bit base, input int k, input int req);
    int m;
    m = 0;
    for (int p = 0; p < NPAR; p++) if (f_pool[p] > m) m = f_pool[p];
    for (int s = NPAR; s < TOTAL; s++)
      expect_slot(s, K_HAM, base ? 8 : exp_flips(k, m, f_pool[s % NPAR]), g_pool[s % NPAR], req);
  endtask

  task automatic check_select();
    bit tk [TOTAL];
    for (int i = 0; i < TOTAL; i++) tk[i] = 0;
    for (int r = 0; r < NPAR; r++) begin
      int best;
      best = -1;
      for (int j = 0; j < TOTAL; j++)
        if (!tk[j] && (best < 0 || f_pool[j] > f_pool[best])) best = j;
      tk[best] = 1;
      expect_slot(r, K_GEN, int'(g_pool[best]), '0, 7); // R7
      expect_slot(r, K_FIT, f_pool[best], '0, 7);       // R7
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(busy, 0, 1); chk(done, 0, 1);
    expect_slot(0, K_GEN, 0, '0, 1);
    expect_slot(63, K_GEN, 0, '0, 1);
    expect_slot(17, K_FIT, 0, '0, 1);

    // R2: seed parents
    cmd(0, 0, 0);
    chk(busy, 1, 9); // R9
    wait_done();
    @(negedge clk);
    chk(done, 0, 9); chk(busy, 0, 9); // R9 single-cycle done
    peek_all();
    begin
      int dup, zero;
      dup = 0; zero = 0;
      for (int i = 0; i < NPAR; i++) begin
        if (g_pool[i] == '0) zero++;
        for (int j = i + 1; j < NPAR; j++) if (g_pool[i] == g_pool[j]) dup++;
      end
      chk(dup, 0, 2); chk(zero, 0, 2); // R2
    end
    expect_slot(5, K_FIT, 0, '0, 2);

    // R3: scaled mutation, R8: write while busy ignored
    for (int p = 0; p < NPAR; p++) wfit(p, 16 * p);
    peek_all();
    cmd(1, 0, 16);
    wfit(3, 200); // R8
    wait_done();
    check_mutation(0, 16, 3);
    for (int p = 0; p < NPAR; p++) begin // R6
      expect_slot(p, K_GEN, int'(g_pool[p]), '0, 6);
      expect_slot(p, K_FIT, f_pool[p], '0, 6);
    end
    expect_slot(3, K_FIT, 48, '0, 8); // R8

    // R5: baseline mode
    cmd(1, 1, 3);
    wait_done();
    check_mutation(1, 3, 5);

    // R4: zero best fitness and clamping
    for (int p = 0; p < NPAR; p++) wfit(p, 0);
    peek_all();
    cmd(1, 0, 20);
    wait_done();
    check_mutation(0, 20, 4);
    cmd(1, 0, 0);
    wait_done();
    check_mutation(0, 0, 4);
    for (int p = 0; p < NPAR; p++) wfit(p, p % 2);
    peek_all();
    cmd(1, 0, 31);
    wait_done();
    check_mutation(0, 31, 4);

    // R7: merged ranking with ties across parents and clones
    for (int i = 0; i < TOTAL; i++) wfit(i, ((i * 7) % 9) * 10);
    peek_all();
    cmd(2, 0, 0);
    wait_done();
    check_select();

    // R7: clones dominate
    for (int i = 0; i < TOTAL; i++) wfit(i, (i < NPAR) ? 5 : 255 - (i % 5));
    peek_all();
    cmd(2, 0, 0);
    wait_done();
    check_select();

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule